// File: doc/BRIEF.md
# Dual Redundant Bus Activity Watchdog

This block watches two redundant serial interrogation lines, a nominal one and a redundant one, and decides from their falling-edge activity which one the terminal should listen to. Every bus line first goes through a short synchronizer clocked by the local oscillator. A two-phase divider then opens a capture window on every second oscillator cycle. Each line has its own watchdog counter, and a captured falling edge clears it. When the counter's top bit is set, that bus is treated as silent. The counter saturates there and does not wrap.

A shared selector turns the two activity flags into a receive choice, with the nominal bus always taking priority. It also drives the per-bus transmit enables and a receive inhibit. A simultaneous-transmit strap lets transmission drive both buses at once. The active-low timeout output is held low while no bus is alive, and it drops for exactly one cycle whenever the selection moves from one bus to the other. Downstream logic uses it as a reset.

The block has no data path, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level signal, sampled or driven on the oscillator clock. The power-on reset is asynchronous and active low. It loads both watchdogs to all ones, so neither bus can appear alive while the oscillator is stopped.

Top module: `dual_bus_watchdog`

## Requirements
- R1: A low-to-high transition on a bus line never makes that bus active. A line that only rises, with no falling edge afterwards, leaves its active flag low.
- R2: Falling edges are captured only in every second oscillator cycle. Of two isolated falling edges whose arrival times differ by an odd number of cycles, exactly one is captured.
- R3: A captured falling edge raises that bus's active flag in the next cycle. With no further capture, the flag stays high for exactly 2**(WD_BITS-1) cycles, then falls and stays low.
- R4: While por_n is low, both active flags are 0, timeout_n is 0, rx_inhibit is 1 and both transmit enables are 0.
- R5: One cycle after both active flags are low, rx_inhibit is 1 and timeout_n is 0. While rx_inhibit is 1, both transmit enables are 0 whatever sim_tx is.
- R6: The selection follows the active flags with one cycle of delay. rx_sel_red is 0 (nominal) whenever the nominal bus was active in the previous cycle. It is 1 (redundant) only when, in the previous cycle, the redundant bus alone was active.
- R7: With sim_tx low, only the selected bus has its transmit enable set. With sim_tx high and a bus selected, both enables are set.
- R8: When the selection moves between nominal and redundant, timeout_n is 0 in the first cycle of the new selection and 1 in the next cycle, provided a bus is still selected.
- R9: A handover from redundant to nominal happens one cycle after the nominal active flag rises. A handover from nominal to redundant waits until the nominal watchdog expires, then happens one cycle after the nominal flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local oscillator clock; all state is updated on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| nom_line | input | 1 | Nominal interrogation bus data line (asynchronous) |
| red_line | input | 1 | Redundant interrogation bus data line (asynchronous) |
| sim_tx | input | 1 | Strap: 1 = transmit on both buses while any bus is selected |
| nom_active | output | 1 | 1 = nominal bus watchdog has not expired |
| red_active | output | 1 | 1 = redundant bus watchdog has not expired |
| rx_sel_red | output | 1 | Receive select: 0 = nominal, 1 = redundant |
| rx_inhibit | output | 1 | 1 = no bus selected, reception on all buses inhibited |
| tx_en_nom | output | 1 | Transmit enable for the nominal bus |
| tx_en_red | output | 1 | Transmit enable for the redundant bus |
| timeout_n | output | 1 | Active-low timeout/reset: low while no bus is selected and for one cycle at each changeover |

## Verification
The bench builds the block with WD_BITS = 5 and SYNC_STAGES = 2. That keeps the expiry window at 16 cycles, so a full capture-to-expiry run, saturation from the all-ones reset value and both handover directions each take only a few dozen cycles. The two-stage synchronizer delay is short enough for the bench to place isolated falling edges on chosen capture phases, one odd cycle apart. A line toggled with a period of three cycles walks through both phases, so a running bus is captured every six cycles, well inside the expiry window.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  // receive selection state
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_NOM  = 2'd1,
    SEL_RED  = 2'd2
  } sel_e;

  localparam int NUM_BUS = 2;
  localparam int NOM_IDX = 0;
  localparam int RED_IDX = 1;
endpackage

// File: rtl/dbw_sync.sv
// Multi-flop synchronizer bringing an asynchronous bus line into the oscillator domain.
module dbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbw_phase.sv
// Two-phase divider: the capture window is open in every second oscillator cycle.
module dbw_phase (
  input  logic clk,
  input  logic rst_n,
  output logic sample_en
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign sample_en = phase_q;
endmodule

// File: rtl/dbw_channel.sv
// Falling-edge capture plus saturating watchdog for one bus.
module dbw_channel #(
  parameter int WD_BITS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic sample_en,
  output logic hit,
  output logic active
);
  localparam int MSB = WD_BITS - 1;

  logic               prev_q;
  logic [WD_BITS-1:0] wd_q;

  // high-to-low only, and only inside the capture window
  assign hit = sample_en & prev_q & ~line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      wd_q   <= '1;            // start silent
    end else begin
      prev_q <= line_s;
      if (hit)
        wd_q <= '0;
      else if (!wd_q[MSB])
        wd_q <= wd_q + 1'b1;   // counts up to the MSB, then holds
    end
  end

  assign active = ~wd_q[MSB];
endmodule

// File: rtl/dbw_select.sv
// Priority selector: nominal wins, one-cycle timeout pulse on every changeover.
module dbw_select
  import dbw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUS-1:0] act,
  input  logic               sim_tx,
  output logic               rx_sel_red,
  output logic               rx_inhibit,
  output logic               timeout_n,
  output logic [NUM_BUS-1:0] tx_en
);
  sel_e target;
  sel_e sel_q;
  logic chg_q;

  always_comb begin
    if (act[NOM_IDX])      target = SEL_NOM;
    else if (act[RED_IDX]) target = SEL_RED;
    else                   target = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
      chg_q <= 1'b0;
    end else begin
      sel_q <= target;
      chg_q <= (target != sel_q);
    end
  end

  assign rx_inhibit = (sel_q == SEL_NONE);
  assign rx_sel_red = (sel_q == SEL_RED);
  assign timeout_n  = ~(rx_inhibit | chg_q);

  assign tx_en[NOM_IDX] = (sel_q == SEL_NOM) | (~rx_inhibit & sim_tx);
  assign tx_en[RED_IDX] = (sel_q == SEL_RED) | (~rx_inhibit & sim_tx);
endmodule

// File: rtl/dual_bus_watchdog.sv
module dual_bus_watchdog
  import dbw_pkg::*;
#(
  parameter int WD_BITS     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic nom_line,
  input  logic red_line,
  input  logic sim_tx,
  output logic nom_active,
  output logic red_active,
  output logic rx_sel_red,
  output logic rx_inhibit,
  output logic tx_en_nom,
  output logic tx_en_red,
  output logic timeout_n
);
  logic [NUM_BUS-1:0] line_raw;
  logic [NUM_BUS-1:0] line_s;
  logic [NUM_BUS-1:0] hit_vec;
  logic [NUM_BUS-1:0] act_vec;
  logic [NUM_BUS-1:0] tx_vec;
  logic               sample_en;

  assign line_raw[NOM_IDX] = nom_line;
  assign line_raw[RED_IDX] = red_line;

  dbw_phase u_phase (
    .clk       (osc_clk),
    .rst_n     (por_n),
    .sample_en (sample_en)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    dbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (osc_clk),
      .rst_n (por_n),
      .d     (line_raw[b]),
      .q     (line_s[b])
    );

    dbw_channel #(.WD_BITS(WD_BITS)) u_chan (
      .clk       (osc_clk),
      .rst_n     (por_n),
      .line_s    (line_s[b]),
      .sample_en (sample_en),
      .hit       (hit_vec[b]),
      .active    (act_vec[b])
    );
  end

  dbw_select u_sel (
    .clk        (osc_clk),
    .rst_n      (por_n),
    .act        (act_vec),
    .sim_tx     (sim_tx),
    .rx_sel_red (rx_sel_red),
    .rx_inhibit (rx_inhibit),
    .timeout_n  (timeout_n),
    .tx_en      (tx_vec)
  );

  assign nom_active = act_vec[NOM_IDX];
  assign red_active = act_vec[RED_IDX];
  assign tx_en_nom  = tx_vec[NOM_IDX];
  assign tx_en_red  = tx_vec[RED_IDX];
endmodule

// File: rtl/dbw_checks.sv
module dbw_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sim_tx,
  input logic       nom_active,
  input logic       red_active,
  input logic       rx_sel_red,
  input logic       rx_inhibit,
  input logic       tx_en_nom,
  input logic       tx_en_red,
  input logic       timeout_n,
  input logic [1:0] hit
);
  // captures cannot occur in two consecutive cycles
  assert_alt_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> !hit[0]);
  assert_alt_phase_red_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> !hit[1]);

  assert_capture_nom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> nom_active);
  assert_capture_red_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |=> red_active);
  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nom_active && !hit[0]) |=> !nom_active);

  assert_idle_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nom_active && !red_active) |=> (rx_inhibit && !timeout_n));
  assert_idle_no_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_inhibit |-> (!tx_en_nom && !tx_en_red));

  assert_nom_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nom_active |=> !rx_sel_red);
  assert_red_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (red_active && !nom_active) |=> rx_sel_red);

  assert_tx_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_tx && !rx_inhibit) |-> (tx_en_nom && tx_en_red));

  assert_change_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_inhibit && !$past(rx_inhibit) && !$stable(rx_sel_red)) |-> !timeout_n);
endmodule

bind dual_bus_watchdog dbw_checks u_checks (
  .clk        (osc_clk),
  .rst_n      (por_n),
  .sim_tx     (sim_tx),
  .nom_active (nom_active),
  .red_active (red_active),
  .rx_sel_red (rx_sel_red),
  .rx_inhibit (rx_inhibit),
  .tx_en_nom  (tx_en_nom),
  .tx_en_red  (tx_en_red),
  .timeout_n  (timeout_n),
  .hit        (hit_vec)
);

// File: tb/dual_bus_watchdog_test.sv
`timescale 1ns/1ps
module dual_bus_watchdog_test;
  localparam int TB_WD   = 5;
  localparam int TB_SYNC = 2;
  localparam int EXP     = 2 ** (TB_WD - 1);

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic nom_man = 1'b1, red_man = 1'b1;
  logic nom_run = 1'b0, red_run = 1'b0;
  logic sim_tx = 1'b0;
  logic nom_line, red_line;
  logic nom_active, red_active, rx_sel_red, rx_inhibit, tx_en_nom, tx_en_red, timeout_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  // 3-cycle toggle pattern: one falling edge every third cycle, walking through both phases
  int pc = 0;
  always @(negedge clk) pc <= (pc == 2) ? 0 : pc + 1;
  assign nom_line = nom_run ? (pc != 0) : nom_man;
  assign red_line = red_run ? (pc != 0) : red_man;

  dual_bus_watchdog #(.WD_BITS(TB_WD), .SYNC_STAGES(TB_SYNC)) uut (
    .osc_clk    (clk),
    .por_n      (por_n),
    .nom_line   (nom_line),
    .red_line   (red_line),
    .sim_tx     (sim_tx),
    .nom_active (nom_active),
    .red_active (red_active),
    .rx_sel_red (rx_sel_red),
    .rx_inhibit (rx_inhibit),
    .tx_en_nom  (tx_en_nom),
    .tx_en_red  (tx_en_red),
    .timeout_n  (timeout_n)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt[2];
  bit m_pipe[2][$];
  bit m_prev[2];
  bit m_phase;
  int m_sel;      // 0 none, 1 nominal, 2 redundant
  bit m_chg;

  always @(posedge clk or negedge por_n) begin
    bit s;
    bit ln[2];
    int tgt;
    if (!por_n) begin
      for (int b = 0; b < 2; b++) begin
        m_cnt[b] = 2 ** TB_WD - 1;
        m_pipe[b].delete();
        for (int i = 0; i < TB_SYNC; i++) m_pipe[b].push_back(1'b0);
        m_prev[b] = 1'b0;
      end
      m_phase = 1'b0;
      m_sel   = 0;
      m_chg   = 1'b0;
    end else begin
      ln[0] = nom_line;
      ln[1] = red_line;
      tgt = (m_cnt[0] < EXP) ? 1 : ((m_cnt[1] < EXP) ? 2 : 0);
      m_chg = (tgt != m_sel);
      m_sel = tgt;
      for (int b = 0; b < 2; b++) begin
        s = m_pipe[b][0];
        if (m_phase && m_prev[b] && !s) m_cnt[b] = 0;
        else if (m_cnt[b] < EXP)        m_cnt[b] = m_cnt[b] + 1;
        m_prev[b] = s;
        void'(m_pipe[b].pop_front());
        m_pipe[b].push_back(ln[b]);
      end
      m_phase = !m_phase;
    end
  end

  // compare on every cycle, away from the clock edge
  always @(negedge clk) begin
    bit e_inh, e_tn, e_txn, e_txr;
    if (por_n) begin
      #1;
      e_inh = (m_sel == 0);
      e_tn  = !(e_inh || m_chg);
      e_txn = (m_sel == 1) || (!e_inh && sim_tx);
      e_txr = (m_sel == 2) || (!e_inh && sim_tx);
      chk(nom_active == (m_cnt[0] < EXP), "R3 nom_active model", nom_active, m_cnt[0] < EXP);
      chk(red_active == (m_cnt[1] < EXP), "R3 red_active model", red_active, m_cnt[1] < EXP);
      chk(rx_sel_red == (m_sel == 2), "R6 rx_sel_red model", rx_sel_red, m_sel == 2);
      chk(rx_inhibit == e_inh, "R5 rx_inhibit model", rx_inhibit, e_inh);
      chk(timeout_n == e_tn, "R8 timeout_n model", timeout_n, e_tn);
      chk(tx_en_nom == e_txn, "R7 tx_en_nom model", tx_en_nom, e_txn);
      chk(tx_en_red == e_txr, "R7 tx_en_red model", tx_en_red, e_txr);
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    int caps, seen, got, len, dly;
    repeat (4) @(negedge clk);
    #1;
    // R4: reset state
    chk(!nom_active && !red_active, "R4 active flags in reset", nom_active + red_active, 0);
    chk(!timeout_n, "R4 timeout_n in reset", timeout_n, 0);
    chk(rx_inhibit, "R4 rx_inhibit in reset", rx_inhibit, 1);
    chk(!tx_en_nom && !tx_en_red, "R4 tx enables in reset", tx_en_nom + tx_en_red, 0);
    @(negedge clk);
    por_n = 1'b1;
    repeat (30) @(negedge clk);

    // R2: two isolated falls an odd number of cycles apart, exactly one captured
    caps = 0;
    nom_man = 1'b0;
    seen = 0;
    repeat (8) begin @(negedge clk); if (nom_active) seen = 1; end
    caps += seen;
    nom_man = 1'b1;
    repeat (25) @(negedge clk);
    nom_man = 1'b0;
    seen = 0;
    repeat (8) begin @(negedge clk); if (nom_active) seen = 1; end
    caps += seen;
    chk(caps == 1, "R2 captures of odd-spaced falls", caps, 1);
    repeat (30) @(negedge clk);

    // R1: a rising edge alone never activates
    nom_man = 1'b1;
    seen = 0;
    repeat (20) begin @(negedge clk); if (nom_active) seen = 1; end
    chk(seen == 0, "R1 rise-only activity", seen, 0);

    // R3: one capture keeps the bus active for exactly EXP cycles
    got = 0;
    for (int t = 0; t < 2 && !got; t++) begin
      nom_man = 1'b0;
      for (int i = 0; i < 8 && !got; i++) begin
        @(negedge clk);
        if (nom_active) got = 1;
      end
      if (!got) begin nom_man = 1'b1; @(negedge clk); end
    end
    chk(got == 1, "R3 capture after retry", got, 1);
    len = 0;
    while (nom_active && len < 64) begin len++; @(negedge clk); end
    chk(len == EXP, "R3 active window length", len, EXP);
    repeat (10) @(negedge clk);
    chk(!nom_active, "R3 stays inactive after expiry", nom_active, 0);
    nom_man = 1'b1;

    // R6/R7: redundant alone selected
    red_run = 1'b1;
    repeat (30) @(negedge clk);
    chk(rx_sel_red && !rx_inhibit, "R6 redundant alone selected", rx_sel_red, 1);
    sim_tx = 1'b1;
    #1;
    chk(tx_en_nom && tx_en_red, "R7 simultaneous transmit", tx_en_nom + tx_en_red, 2);
    @(negedge clk);
    sim_tx = 1'b0;
    #1;
    chk(tx_en_red && !tx_en_nom, "R7 transmit follows receive", {tx_en_nom, tx_en_red}, 1);

    // R9/R8: redundant -> nominal handover
    @(negedge clk);
    nom_run = 1'b1;
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (nom_active) got = 1;
    end
    chk(got == 1, "R9 nominal becomes active", got, 1);
    @(negedge clk);
    chk(!rx_sel_red, "R9 nominal taken one cycle after rise", rx_sel_red, 0);
    chk(!timeout_n, "R8 pulse on red->nom", timeout_n, 0);
    @(negedge clk);
    chk(timeout_n, "R8 pulse one cycle wide", timeout_n, 1);

    // R9/R8: nominal -> redundant only after expiry
    repeat (10) @(negedge clk);
    nom_man = 1'b1;
    nom_run = 1'b0;
    dly = 0;
    while (nom_active && dly < 64) begin
      chk(!rx_sel_red, "R9 nominal held until expiry", rx_sel_red, 0);
      dly++;
      @(negedge clk);
    end
    chk(dly >= EXP / 2, "R9 nom->red delay", dly, EXP / 2);
    chk(!rx_sel_red, "R9 selection lags flag by one cycle", rx_sel_red, 0);
    @(negedge clk);
    chk(rx_sel_red, "R9 redundant taken after expiry", rx_sel_red, 1);
    chk(!timeout_n, "R8 pulse on nom->red", timeout_n, 0);
    @(negedge clk);
    chk(timeout_n, "R8 pulse width nom->red", timeout_n, 1);

    // R5: both silent
    red_man = 1'b1;
    red_run = 1'b0;
    repeat (40) @(negedge clk);
    sim_tx = 1'b1;
    #1;
    chk(rx_inhibit, "R5 inhibit when silent", rx_inhibit, 1);
    chk(!timeout_n, "R5 timeout held low", timeout_n, 0);
    chk(!tx_en_nom && !tx_en_red, "R5 no transmit with strap", tx_en_nom + tx_en_red, 0);
    @(negedge clk);
    sim_tx = 1'b0;

    // both running: nominal priority, model compares throughout
    nom_run = 1'b1;
    red_run = 1'b1;
    repeat (40) @(negedge clk);
    chk(!rx_sel_red && !rx_inhibit, "R6 both active picks nominal", rx_sel_red, 0);
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule